// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block reads one instruction of a compact 32-bit teaching instruction set. It reads the instruction one byte at a time from a byte-addressed memory. When `start` is sampled, it takes the fetch address, requests the leading byte and splits that byte into a 4-bit opcode and a 4-bit function code. The opcode then decides whether a register-specifier byte follows, whether a little-endian immediate follows, or both. The block fetches only the bytes that the instruction actually contains. Instructions are therefore 1, 2, 5 or 6 bytes long.

When the fetch ends, the block raises `done` for a single cycle. It then presents the decoded fields, the address of the next sequential instruction and a 2-bit status. The status separates four cases: a normal instruction, a halt, a byte address beyond the end of memory, and an opcode outside the defined set. A fetch that touches a missing address does not issue that read. It reports its opcode as a NOP, so later stages see a harmless instruction.

The memory side is a plain request/response port. `mem_req` is high for one cycle with `mem_addr`. The block then waits, however many cycles it takes, for `mem_rvalid` with the byte on `mem_rdata`.

Top module: `vlf_fetch_decoder`

## Requirements
- R1: After reset, `done` and `mem_req` are 0, `status` is 0, `opcode`, `func`, `imm` and `next_pc` are 0, and both register IDs are 0xF.
- R2: The leading byte gives `opcode` from bits 7:4 and `func` from bits 3:0.
- R3: A register byte is read only for opcodes 2, 3, 4, 5, 6, 0xA and 0xB. Its bits 7:4 go to `reg_a` and bits 3:0 go to `reg_b`. For every other opcode both IDs report 0xF.
- R4: An immediate of IMM_BYTES bytes is read only for opcodes 3, 4, 5, 7 and 8. It is assembled little-endian, so the first byte fetched lands in bits 7:0. For every other opcode `imm` reports 0.
- R5: Requests go to consecutive addresses starting at the fetch address, one request per instruction byte. On success, `next_pc` equals the fetch address plus 1, plus 1 when a register byte exists, plus IMM_BYTES when an immediate exists.
- R6: Status encoding: 0 = OK, 1 = halt (opcode 0), 2 = address fault, 3 = invalid opcode (above 0xB). A halt or an invalid opcode ends the fetch after the leading byte, with `next_pc` equal to the fetch address plus 1.
- R7: A byte address at or above MEM_BYTES is never requested. The fetch ends at once with status 2, `opcode` 1, `func` 0, and `next_pc` equal to the address that could not be read.
- R8: `done` is high for exactly one cycle per fetch. After it, `opcode`, `func`, both register IDs, `imm`, `next_pc` and `status` stay unchanged until the next accepted `start`.
- R9: A `start` that arrives while a fetch is in progress is ignored, together with its `fetch_pc`.
- R10: At most one memory request is outstanding at a time. Any response delay of one or more cycles gives the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch when idle |
| fetch_pc | input | ADDR_W | Address of the instruction's leading byte |
| done | output | 1 | One-cycle pulse when results are valid |
| mem_req | output | 1 | Byte read request, one cycle |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_rvalid | input | 1 | Response strobe for the outstanding request |
| mem_rdata | input | 8 | Byte returned with the response |
| opcode | output | 4 | Decoded opcode (1 after an address fault) |
| func | output | 4 | Decoded function code (0 after an address fault) |
| reg_a | output | 4 | First register ID, 0xF when absent |
| reg_b | output | 4 | Second register ID, 0xF when absent |
| imm | output | 8*IMM_BYTES | Little-endian immediate, 0 when absent |
| next_pc | output | ADDR_W | Next sequential address, or faulting address |
| status | output | 2 | 0 OK, 1 halt, 2 address fault, 3 invalid |

## Verification
The embedded assertions check several properties on every cycle:
- `done` never lasts more than one cycle.
- Only one memory request is outstanding at a time.
- Outputs are frozen whenever the block is idle and not starting.
- A faulted fetch always reports NOP with function 0.
- An invalid status always goes with an opcode outside the legal set.
- A successful `next_pc` always matches the length implied by the held opcode.

Only the bench's sweep can show the remaining behaviour, using every opcode at fetch addresses placed on and around the end of memory, under varying response delays:
- that the right fields land in the right bits,
- that the immediate byte order is right,
- that the request count matches the instruction length,
- that the fault lands on the exact first missing address,
- that a `start` during a fetch changes nothing.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

   typedef enum logic [1:0] {
      FS_OK      = 2'd0,
      FS_HALT    = 2'd1,
      FS_ADDR    = 2'd2,
      FS_INVALID = 2'd3
   } fetch_status_e;

   localparam logic [3:0] OPC_HALT      = 4'h0;
   localparam logic [3:0] OPC_NOP       = 4'h1;
   localparam logic [3:0] OPC_MAX_LEGAL = 4'hB;
   localparam logic [3:0] REG_ABSENT    = 4'hF;

   // bit n set: opcode n carries that field
   localparam logic [15:0] REG_BYTE_MASK = 16'h0C7C;
   localparam logic [15:0] IMM_FIELD_MASK = 16'h01B8;

endpackage

// File: rtl/vlf_classify.sv
module vlf_classify
   import vlf_pkg::*;
(
   input  logic [3:0] op,
   output logic       has_reg,
   output logic       has_imm,
   output logic       legal
);

   assign has_reg = REG_BYTE_MASK[op];
   assign has_imm = IMM_FIELD_MASK[op];
   assign legal   = (op <= OPC_MAX_LEGAL);

endmodule

// File: rtl/vlf_addr_guard.sv
module vlf_addr_guard #(
   parameter int ADDR_W    = 32,
   parameter int MEM_BYTES = 4096
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_range
);

   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

   assign in_range = ({1'b0, addr} < LIMIT);

endmodule

// File: rtl/vlf_imm_lanes.sv
module vlf_imm_lanes #(
   parameter int IMM_BYTES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   load,
   input  logic [LANE_W-1:0]      lane_sel,
   input  logic [7:0]             byte_in,
   output logic [8*IMM_BYTES-1:0] imm_word
);

   localparam int LANE_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;

   for (genvar g = 0; g < IMM_BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (clear)
            lane_q <= '0;
         else if (load && (lane_sel == LANE_W'(g)))
            lane_q <= byte_in;
      end
      assign imm_word[8*g +: 8] = lane_q;
   end

endmodule

// File: rtl/vlf_fetch_decoder.sv
module vlf_fetch_decoder
   import vlf_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MEM_BYTES = 4096,
   parameter int IMM_BYTES = 4,
   localparam int IMM_W    = 8 * IMM_BYTES,
   localparam int LANE_W   = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic              done,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [7:0]        mem_rdata,
   output logic [3:0]        opcode,
   output logic [3:0]        func,
   output logic [3:0]        reg_a,
   output logic [3:0]        reg_b,
   output logic [IMM_W-1:0]  imm,
   output logic [ADDR_W-1:0] next_pc,
   output logic [1:0]        status
);

   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
      $error("vlf_fetch_decoder: ADDR_W must lie in 2..32");
   end
   if (MEM_BYTES < 1 || longint'(MEM_BYTES) > (64'd1 << ADDR_W)) begin : g_bad_mem
      $error("vlf_fetch_decoder: MEM_BYTES must fit the address space");
   end
   if (IMM_BYTES < 1 || IMM_BYTES > 8) begin : g_bad_imm
      $error("vlf_fetch_decoder: IMM_BYTES must lie in 1..8");
   end

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;
   typedef enum logic [1:0] {PH_OP, PH_REG, PH_IMM} phase_e;

   state_e          state_q;
   phase_e          phase_q;
   logic [ADDR_W-1:0] cur_addr_q, pc_base_q, next_pc_q;
   logic [LANE_W-1:0] lane_q;
   logic [3:0]      opcode_q, func_q, rega_q, regb_q;
   fetch_status_e   status_q;
   logic            done_q;

   logic new_reg, new_imm, new_legal;
   logic held_reg, held_imm, held_legal;
   logic addr_ok;
   logic [3:0] rd_op;
   logic accept, imm_load;

   assign rd_op    = mem_rdata[7:4];
   assign accept   = (state_q == S_IDLE) && start;
   assign imm_load = (state_q == S_WAIT) && mem_rvalid && (phase_q == PH_IMM);

   vlf_classify u_cls_new  (.op(rd_op),    .has_reg(new_reg),  .has_imm(new_imm),  .legal(new_legal));
   vlf_classify u_cls_held (.op(opcode_q), .has_reg(held_reg), .has_imm(held_imm), .legal(held_legal));

   vlf_addr_guard #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_guard (
      .addr(cur_addr_q), .in_range(addr_ok));

   vlf_imm_lanes #(.IMM_BYTES(IMM_BYTES)) u_imm (
      .clk(clk), .rst_n(rst_n), .clear(accept), .load(imm_load),
      .lane_sel(lane_q), .byte_in(mem_rdata), .imm_word(imm));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         phase_q    <= PH_OP;
         cur_addr_q <= '0;
         pc_base_q  <= '0;
         next_pc_q  <= '0;
         lane_q     <= '0;
         opcode_q   <= '0;
         func_q     <= '0;
         rega_q     <= REG_ABSENT;
         regb_q     <= REG_ABSENT;
         status_q   <= FS_OK;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start) begin
                  cur_addr_q <= fetch_pc;
                  pc_base_q  <= fetch_pc;
                  phase_q    <= PH_OP;
                  lane_q     <= '0;
                  opcode_q   <= '0;
                  func_q     <= '0;
                  rega_q     <= REG_ABSENT;
                  regb_q     <= REG_ABSENT;
                  status_q   <= FS_OK;
                  state_q    <= S_ISSUE;
               end
            end
            S_ISSUE: begin
               if (!addr_ok) begin
                  status_q  <= FS_ADDR;
                  opcode_q  <= OPC_NOP;
                  func_q    <= '0;
                  next_pc_q <= cur_addr_q;
                  done_q    <= 1'b1;
                  state_q   <= S_IDLE;
               end else begin
                  state_q <= S_WAIT;
               end
            end
            S_WAIT: begin
               if (mem_rvalid) begin
                  cur_addr_q <= cur_addr_q + ADDR_W'(1);
                  state_q    <= S_ISSUE;
                  unique case (phase_q)
                     PH_OP: begin
                        opcode_q <= rd_op;
                        func_q   <= mem_rdata[3:0];
                        if (rd_op == OPC_HALT || !new_legal) begin
                           status_q  <= (rd_op == OPC_HALT) ? FS_HALT : FS_INVALID;
                           next_pc_q <= cur_addr_q + ADDR_W'(1);
                           done_q    <= 1'b1;
                           state_q   <= S_IDLE;
                        end else if (new_reg) begin
                           phase_q <= PH_REG;
                        end else if (new_imm) begin
                           phase_q <= PH_IMM;
                        end else begin
                           next_pc_q <= cur_addr_q + ADDR_W'(1);
                           done_q    <= 1'b1;
                           state_q   <= S_IDLE;
                        end
                     end
                     PH_REG: begin
                        rega_q <= mem_rdata[7:4];
                        regb_q <= mem_rdata[3:0];
                        if (held_imm) begin
                           phase_q <= PH_IMM;
                        end else begin
                           next_pc_q <= cur_addr_q + ADDR_W'(1);
                           done_q    <= 1'b1;
                           state_q   <= S_IDLE;
                        end
                     end
                     default: begin
                        if (lane_q == LANE_W'(IMM_BYTES - 1)) begin
                           next_pc_q <= cur_addr_q + ADDR_W'(1);
                           done_q    <= 1'b1;
                           state_q   <= S_IDLE;
                        end else begin
                           lane_q <= lane_q + LANE_W'(1);
                        end
                     end
                  endcase
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign mem_req  = (state_q == S_ISSUE) && addr_ok;
   assign mem_addr = cur_addr_q;
   assign done     = done_q;
   assign opcode   = opcode_q;
   assign func     = func_q;
   assign reg_a    = rega_q;
   assign reg_b    = regb_q;
   assign next_pc  = next_pc_q;
   assign status   = status_q;

   // R8: completion strobe lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: idle without a new start keeps every result frozen
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && !start) |=>
         ($stable(next_pc) && $stable(status) && $stable(opcode) && $stable(func)
          && $stable(reg_a) && $stable(reg_b) && $stable(imm)));

   // R10: a request is never followed directly by another
   p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R7: a faulted fetch reports a NOP with function 0
   p_fault_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == FS_ADDR) |-> (opcode == OPC_NOP && func == 4'h0));

   // R6: invalid status only for an opcode outside the legal set
   p_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == FS_INVALID) |-> !held_legal);

   // R5: successful length agrees with the held opcode's field needs
   p_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == FS_OK) |->
         (next_pc == pc_base_q + ADDR_W'(1) + ADDR_W'(held_reg)
                     + (held_imm ? ADDR_W'(IMM_BYTES) : '0)));

endmodule

// File: tb/vlf_fetch_decoder_tb.sv
module vlf_fetch_decoder_tb;

   localparam int AW   = 8;
   localparam int MEMB = 64;
   localparam int IMMB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic done, mem_req;
   logic [AW-1:0] mem_addr;
   logic mem_rvalid = 1'b0;
   logic [7:0] mem_rdata = '0;
   logic [3:0] opcode, func, reg_a, reg_b;
   logic [8*IMMB-1:0] imm;
   logic [AW-1:0] next_pc;
   logic [1:0] status;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   int lat = 0;
   int req_count = 0;
   logic pend = 1'b0;
   int cnt = 0;
   logic [AW-1:0] paddr = '0;
   logic [7:0] mem [0:255];

   always #10 clk = ~clk;

   vlf_fetch_decoder #(.ADDR_W(AW), .MEM_BYTES(MEMB), .IMM_BYTES(IMMB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .fetch_pc(fetch_pc), .done(done),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .opcode(opcode), .func(func), .reg_a(reg_a),
      .reg_b(reg_b), .imm(imm), .next_pc(next_pc), .status(status));

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[paddr];
            pend       <= 1'b0;
         end else begin
            cnt <= cnt - 1;
         end
      end
      if (mem_req) begin
         pend      <= 1'b1;
         cnt       <= lat;
         paddr     <= mem_addr;
         req_count <= req_count + 1;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         $display("FAIL watchdog act=expired exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (done) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   function automatic bit f_reg(input int op);
      return (op >= 2 && op <= 6) || op == 10 || op == 11;
   endfunction
   function automatic bit f_imm(input int op);
      return (op >= 3 && op <= 5) || op == 7 || op == 8;
   endfunction

   task automatic one_fetch(input int op, input int pc, input int l);
      int fn, rb, len, offs, base_req, exp_req, fault_at;
      logic [31:0] iv;
      bit ok, nr, ni;
      logic [AW-1:0] snap_pc;
      logic [1:0] snap_st;
      fn = (op * 7 + 3) & 15;
      rb = (op * 29 + pc * 3 + 1) & 255;
      nr = f_reg(op);
      ni = f_imm(op);
      mem[pc & 255] = 8'((op << 4) | fn);
      mem[(pc + 1) & 255] = 8'(rb);
      offs = 1 + int'(nr);
      iv = '0;
      for (int k = 0; k < 4; k++) begin
         logic [7:0] b;
         b = 8'((pc * 11 + op * 5 + k * 53 + 7) & 255);
         if (ni) mem[(pc + offs + k) & 255] = b;
         iv[8*k +: 8] = b;
      end
      if (op == 0 || op > 11) len = 1;
      else len = 1 + int'(nr) + (ni ? 4 : 0);
      fault_at = -1;
      if (pc >= MEMB) fault_at = pc;
      else if (pc + len - 1 >= MEMB) fault_at = MEMB;
      lat = l;
      base_req = req_count;
      fetch_pc = AW'(pc);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk("R8 done seen", 64'(ok), 64'd1);
      if (!ok) return;
      if (fault_at >= 0) begin
         chk("R7 status", 64'(status), 64'd2);
         chk("R7 opcode", 64'(opcode), 64'd1);
         chk("R7 func", 64'(func), 64'd0);
         chk("R7 next_pc", 64'(next_pc), 64'(fault_at));
         exp_req = fault_at - pc;
      end else begin
         chk("R6 status", 64'(status), (op == 0) ? 64'd1 : (op > 11) ? 64'd3 : 64'd0);
         chk("R2 opcode", 64'(opcode), 64'(op));
         chk("R2 func", 64'(func), 64'(fn));
         chk("R3 reg_a", 64'(reg_a), (nr && op <= 11 && op != 0) ? 64'(rb >> 4) : 64'hF);
         chk("R3 reg_b", 64'(reg_b), (nr && op <= 11 && op != 0) ? 64'(rb & 15) : 64'hF);
         chk("R4 imm", 64'(imm), (ni && op <= 11 && op != 0) ? 64'(iv) : 64'd0);
         chk("R5 next_pc", 64'(next_pc), 64'(pc + len));
         exp_req = len;
      end
      @(negedge clk);
      chk("R8 done pulse", 64'(done), 64'd0);
      chk("R5 R10 requests", 64'(req_count - base_req), 64'(exp_req));
      snap_pc = next_pc;
      snap_st = status;
      for (int i = 0; i < 3; i++) @(negedge clk);
      chk("R8 hold next_pc", 64'(next_pc), 64'(snap_pc));
      chk("R8 hold status", 64'(status), 64'(snap_st));
   endtask

   initial begin
      int pcs [7];
      bit ok;
      pcs = '{0, 10, 58, 59, 60, 63, 64};
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 mem_req", 64'(mem_req), 64'd0);
      chk("R1 status", 64'(status), 64'd0);
      chk("R1 opcode", 64'(opcode), 64'd0);
      chk("R1 reg_a", 64'(reg_a), 64'hF);
      chk("R1 reg_b", 64'(reg_b), 64'hF);
      chk("R1 imm", 64'(imm), 64'd0);
      chk("R1 next_pc", 64'(next_pc), 64'd0);

      for (int op = 0; op < 16; op++)
         for (int p = 0; p < 7; p++)
            one_fetch(op, pcs[p], (op + p) % 3);

      // R9: second start during a fetch is ignored
      mem[20] = 8'h35; mem[21] = 8'h7C;
      mem[22] = 8'h11; mem[23] = 8'h22; mem[24] = 8'h33; mem[25] = 8'h44;
      mem[30] = 8'h00;
      lat = 1;
      fetch_pc = 8'd20;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      fetch_pc = 8'd30;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk("R9 done", 64'(ok), 64'd1);
      chk("R9 status", 64'(status), 64'd0);
      chk("R9 opcode", 64'(opcode), 64'd3);
      chk("R9 reg_a", 64'(reg_a), 64'h7);
      chk("R9 imm", 64'(imm), 64'h44332211);
      chk("R9 next_pc", 64'(next_pc), 64'd26);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule